// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the status word of a 32-bit processor core. The four condition flags (negative, zero, carry, overflow) are kept apart from the control bits. The zero flag is stored as a result value and is tested against zero when the word is read. The read port is combinational and returns the packed word: the flags sit in the top nibble and the stored control field fills every other bit.

Software writes give a value, a per-bit mask and a write enable. When any flag bit is selected in the mask, all four flags reload from the written nibble. The remaining selected bits merge into the control field, and flag positions are stripped from the mask first. The ALU can update the flags in the same cycle as a write, but a software flag write overrides it.

When a write alters any bit of the 5-bit mode field (bits 4..0), the block raises a request for one cycle. The request carries the new mode value and accompanies the updated register. A mode-switching unit outside the block acts on it.

The design has no branching control flow. Its only sequencing is the one-cycle request, in two named states. IDLE is the state in which no request is pending. FIRE is the cycle in which the request is presented. The transition IDLE to FIRE is taken on a mode-changing write. FIRE returns to IDLE when the next cycle has no mode change, and stays in FIRE when it does.

Top module: `status_word_reg`

## Requirements
- R1: `rd_data` bit 31 is N, bit 30 is Z, bit 29 is C and bit 28 is V. Bits 27..0 come from the stored control field.
- R2: Z reads 1 exactly when the stored zero-indicator value is zero. An ALU update stores `alu_result` as that value, and a software flag write stores a nonzero value when bit 30 is 0 and zero when it is 1.
- R3: A write (`wr_en`=1) whose mask has any of bits 31..28 set reloads all four flags from `wr_data[31:28]`.
- R4: The control field never holds copies of flag bits. After any write, bits 31..28 of `rd_data` depend only on the flags.
- R5: For bits 27..0, a write sets each bit whose mask bit is 1 to the written value, and each bit whose mask bit is 0 keeps its value.
- R6: A write that changes at least one bit of the mode field (bits 4..0) sets `mode_req` for exactly the following cycle. During that cycle `mode_val` equals the new mode, which matches `rd_data[4:0]`.
- R7: `mode_req` stays 0 after a write whose selected mode bits equal the current mode, and after a write that selects no mode bits.
- R8: With `alu_we`=1, the flags load N from `alu_n`, C from `alu_c`, V from `alu_v` and the zero indicator from `alu_result`. A software write covering the flags in the same cycle takes priority over the ALU update.
- R9: An ALU flag update and a control-only write in the same cycle both take effect.
- R10: After reset all flags read 0, the control field equals RESET_MODE in bits 4..0 with all other bits 0, and `mode_req` is 0.
- R11: While `wr_en`=0, the mask and data have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value to write |
| wr_mask | input | 32 | Per-bit select for the write |
| alu_we | input | 1 | ALU flag update strobe |
| alu_n | input | 1 | ALU negative flag |
| alu_c | input | 1 | ALU carry flag |
| alu_v | input | 1 | ALU overflow flag |
| alu_result | input | 32 | ALU result, used as the zero indicator |
| rd_data | output | 32 | Packed status word |
| mode_req | output | 1 | Single-cycle mode-switch request |
| mode_val | output | 5 | New mode that accompanies the request |

## Verification
The bench selects a single flag bit in the mask and checks that all four flags reload. A design that tested only bit 31 would leave C and V stale. A full-mask write checks that flag bits never reach the control field; a design that kept them would not clear its top nibble after a later flag write. The bench also targets three cases:
- A write that selects mode bits but leaves them unchanged must not raise a request, and a design that fired on any mode-selecting write would raise a spurious one.
- When a software flag write and an ALU update arrive together, a design with the priority reversed would show the ALU flags.
- A zero indicator that is zero, and one that is nonzero but not one, catch a design that tested only the low bit.

// File: rtl/swr_pkg.sv
package swr_pkg;
    localparam int FLAG_CNT = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_FIRE = 1'b1
    } req_state_t;
endpackage

// File: rtl/swr_flag_unit.sv
module swr_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_load,
    input  swr_pkg::nzcv_t     sw_nzcv,
    input  logic               alu_we,
    input  logic               alu_n,
    input  logic               alu_c,
    input  logic               alu_v,
    input  logic [WIDTH-1:0]   alu_result,
    output swr_pkg::nzcv_t     flags
);
    localparam logic [WIDTH-1:0] ZRES_CLEAR = WIDTH'(1);

    logic             n_q, c_q, v_q;
    logic [WIDTH-1:0] zres_q;
    logic             n_d, c_d, v_d;
    logic [WIDTH-1:0] zres_d;

    always_comb begin
        n_d    = n_q;
        c_d    = c_q;
        v_d    = v_q;
        zres_d = zres_q;
        if (sw_load) begin
            n_d    = sw_nzcv.n;
            c_d    = sw_nzcv.c;
            v_d    = sw_nzcv.v;
            zres_d = sw_nzcv.z ? '0 : ZRES_CLEAR;
        end else if (alu_we) begin
            n_d    = alu_n;
            c_d    = alu_c;
            v_d    = alu_v;
            zres_d = alu_result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= 1'b0;
            c_q    <= 1'b0;
            v_q    <= 1'b0;
            zres_q <= ZRES_CLEAR;
        end else begin
            n_q    <= n_d;
            c_q    <= c_d;
            v_q    <= v_d;
            zres_q <= zres_d;
        end
    end

    always_comb begin
        flags.n = n_q;
        flags.z = (zres_q == '0);
        flags.c = c_q;
        flags.v = v_q;
    end

    // R3 R8
    sw_flag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> flags == $past(sw_nzcv));

    // R8
    alu_flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !sw_load) |=> (flags.n == $past(alu_n)) && (flags.c == $past(alu_c))
                                 && (flags.v == $past(alu_v)));

    // R2
    zero_from_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !sw_load) |=> flags.z == ($past(alu_result) == '0));
endmodule

// File: rtl/swr_ctrl_unit.sv
module swr_ctrl_unit #(
    parameter int                     WIDTH      = 32,
    parameter int                     MODE_W     = 5,
    parameter logic [MODE_W-1:0]      RESET_MODE = 5'h13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    output logic [WIDTH-1:0] ctrl
);
    localparam int              FLAG_LO    = WIDTH - swr_pkg::FLAG_CNT;
    localparam logic [WIDTH-1:0] FLAG_FIELD = {{swr_pkg::FLAG_CNT{1'b1}}, {FLAG_LO{1'b0}}};
    localparam logic [WIDTH-1:0] CTRL_RESET = WIDTH'(RESET_MODE);

    logic [WIDTH-1:0] ctrl_q, ctrl_d, sel;

    always_comb begin
        sel    = wr_en ? (wr_mask & ~FLAG_FIELD) : '0;
        ctrl_d = (ctrl_q & ~sel) | (wr_data & sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    // R4
    no_flag_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[WIDTH-1:FLAG_LO] == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/swr_mode_watch.sv
module swr_mode_watch #(
    parameter int MODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [MODE_W-1:0] wr_sel,
    input  logic [MODE_W-1:0] cur_mode,
    output logic              req,
    output logic [MODE_W-1:0] req_mode
);
    import swr_pkg::*;

    req_state_t        st_q, st_d;
    logic [MODE_W-1:0] val_q, val_d;
    logic              changes;

    always_comb begin
        changes = wr_en && (((cur_mode ^ wr_mode) & wr_sel) != '0);
        val_d   = val_q;
        st_d    = REQ_IDLE;
        if (changes) begin
            st_d  = REQ_FIRE;
            val_d = (cur_mode & ~wr_sel) | (wr_mode & wr_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= REQ_IDLE;
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            val_q <= val_d;
        end
    end

    always_comb begin
        unique case (st_q)
            REQ_IDLE: req = 1'b0;
            REQ_FIRE: req = 1'b1;
            default:  req = 1'b0;
        endcase
        req_mode = val_q;
    end

    // R6
    req_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(wr_en));

    // R7
    no_req_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == '0) |=> !req);
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg #(
    parameter int                WIDTH      = 32,
    parameter int                MODE_W     = 5,
    parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  wr_mask,
    input  logic              alu_we,
    input  logic              alu_n,
    input  logic              alu_c,
    input  logic              alu_v,
    input  logic [WIDTH-1:0]  alu_result,
    output logic [WIDTH-1:0]  rd_data,
    output logic              mode_req,
    output logic [MODE_W-1:0] mode_val
);
    localparam int FLAG_LO = WIDTH - swr_pkg::FLAG_CNT;

    swr_pkg::nzcv_t   flags;
    swr_pkg::nzcv_t   sw_nzcv;
    logic             sw_load;
    logic [WIDTH-1:0] ctrl;

    assign sw_load = wr_en && (wr_mask[WIDTH-1:FLAG_LO] != '0);
    assign sw_nzcv = wr_data[WIDTH-1:FLAG_LO];

    swr_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_load    (sw_load),
        .sw_nzcv    (sw_nzcv),
        .alu_we     (alu_we),
        .alu_n      (alu_n),
        .alu_c      (alu_c),
        .alu_v      (alu_v),
        .alu_result (alu_result),
        .flags      (flags)
    );

    swr_ctrl_unit #(.WIDTH(WIDTH), .MODE_W(MODE_W), .RESET_MODE(RESET_MODE)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .ctrl    (ctrl)
    );

    swr_mode_watch #(.MODE_W(MODE_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_mode  (wr_data[MODE_W-1:0]),
        .wr_sel   (wr_mask[MODE_W-1:0]),
        .cur_mode (ctrl[MODE_W-1:0]),
        .req      (mode_req),
        .req_mode (mode_val)
    );

    assign rd_data = {flags, ctrl[FLAG_LO-1:0]};

    // R6
    req_mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req |-> mode_val == rd_data[MODE_W-1:0]);

    // R5
    unselected_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask[FLAG_LO-1:0] == '0) |=> $stable(rd_data[FLAG_LO-1:0]));

    // R1
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_load && !alu_we) |=> $stable(rd_data[WIDTH-1:FLAG_LO]));
endmodule

// File: tb/tb_status_word_reg.sv
module tb_status_word_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic        alu_we = 1'b0;
    logic        alu_n = 1'b0;
    logic        alu_c = 1'b0;
    logic        alu_v = 1'b0;
    logic [31:0] alu_result = '0;
    logic [31:0] rd_data;
    logic        mode_req;
    logic [4:0]  mode_val;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    status_word_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
        .alu_we(alu_we), .alu_n(alu_n), .alu_c(alu_c), .alu_v(alu_v),
        .alu_result(alu_result), .rd_data(rd_data), .mode_req(mode_req), .mode_val(mode_val)
    );

    localparam int NV = 7;
    // R3 R5 R4 R6 R7 vectors, applied in order from reset
    localparam logic [31:0] V_DATA [NV] = '{32'hF000_0000, 32'h0000_0000, 32'h0000_00C0,
        32'hA5A5_A5BF, 32'h5000_0011, 32'h0000_0011, 32'h0000_0007};
    localparam logic [31:0] V_MASK [NV] = '{32'h8000_0000, 32'h1000_0000, 32'h0000_00FF,
        32'h0000_FF00, 32'hFFFF_FFFF, 32'h0000_001F, 32'h0000_0004};
    localparam logic [31:0] V_RD   [NV] = '{32'hF000_0013, 32'h0000_0013, 32'h0000_00C0,
        32'h0000_A5C0, 32'h5000_0011, 32'h5000_0011, 32'h5000_0015};
    localparam logic        V_REQ  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [4:0]  V_MODE [NV] = '{5'h00, 5'h00, 5'h00, 5'h00, 5'h11, 5'h00, 5'h15};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] d, input logic [31:0] m,
                        input logic aw, input logic an, input logic ac, input logic av,
                        input logic [31:0] ar);
        @(negedge clk);
        wr_en = we; wr_data = d; wr_mask = m;
        alu_we = aw; alu_n = an; alu_c = ac; alu_v = av; alu_result = ar;
        @(posedge clk); #1;
        @(negedge clk);
        wr_en = 1'b0; alu_we = 1'b0;
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset word", rd_data, 32'h0000_0013);
        chk("R10 reset req", {31'b0, mode_req}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = V_DATA[i]; wr_mask = V_MASK[i];
            @(posedge clk); #1;
            chk("R1 R3 R5 vector word", rd_data, V_RD[i]);
            chk("R6 R7 vector req", {31'b0, mode_req}, {31'b0, V_REQ[i]});
            if (V_REQ[i]) chk("R6 vector mode", {27'b0, mode_val}, {27'b0, V_MODE[i]});
            @(negedge clk); wr_en = 1'b0;
            @(posedge clk); #1;
            chk("R6 pulse single cycle", {31'b0, mode_req}, 32'h0);
        end

        // R11 masked data ignored while wr_en low
        step(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R11 no write", rd_data, 32'h5000_0015);

        // R8 R2 ALU update, zero result
        step(1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0);
        chk("R8 R2 alu zero", rd_data, 32'hD000_0015);

        // R2 nonzero result with low bit clear
        step(1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0100);
        chk("R2 alu nonzero", rd_data, 32'h2000_0015);

        // R8 software flag write wins over ALU
        step(1'b1, 32'h0000_0000, 32'hF000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0);
        chk("R8 priority", rd_data, 32'h0000_0015);

        // R9 ALU and control-only write together
        step(1'b1, 32'h0000_0A15, 32'h0000_0F00, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0);
        chk("R9 both apply", rd_data, 32'hF000_0A15);

        // R4 flag write after full-mask write leaves control top clear
        step(1'b1, 32'h0000_0000, 32'h2000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R4 no flag copy", rd_data, 32'h0000_0A15);

        // R7 mode bits selected but unchanged
        step(1'b1, 32'h0000_0015, 32'h0000_001F, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R7 same mode", {31'b0, mode_req}, 32'h0);

        // R10 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R10 reset again", rd_data, 32'h0000_0013);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule